// File: doc/BRIEF.md
# Registered PAL Macrocell Array

A small simple programmable logic device. It is a row of macrocells, and each macrocell has the same structure. A few programmable product terms feed one fixed OR gate. The OR output goes to a D flip-flop. A per-cell mode bit then routes either the OR output or the flip-flop output to the cell's pin. All pins pass through a tri-state stage that one shared output enable controls. Each flip-flop output returns to every product term as a true literal and as a complemented literal. The registered cells therefore form a state machine whose next-state logic is the AND-OR array.

The configuration is a single serial chain. It holds every literal-enable bit of every product term and every cell's mode bit. It loads one bit per clock while the shift enable is high. The macrocell flip-flops are frozen during loading, so a half-loaded array does not disturb the state. A synchronous reset clears only the flip-flops. The array is configured once and then runs from the pins with no further help.

Top module: `pal_array`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge moves the chain by one place toward its top bit, and `cfg_in` enters bit 0. The first bit sent therefore ends in bit CFG_W-1 after CFG_W shifts. Cell c occupies bits [c*CELL_W +: CELL_W]. Bit 0 of a cell is its mode bit. Term t of cell c uses bits [1 + t*LIT_W +: LIT_W] of that cell.
- R2: The chain keeps its contents while `cfg_en` is low, and `rst` never changes it.
- R3: The array has signals 0..N_IN-1, which are `in_pins`, and signals N_IN..N_IN+N_CELL-1, which are the flip-flops of cells 0..N_CELL-1. Within a term, enable bit 2k connects signal k and enable bit 2k+1 connects the complement of signal k. A term is the AND of its connected literals.
- R4: Each cell ORs its N_PT terms. A term with every literal connected always evaluates to 0, so it never raises the OR output.
- R5: When the mode bit is 0, the pin follows the OR output in the same cycle, including changes on `in_pins`.
- R6: When the mode bit is 1, the pin shows the flip-flop. The flip-flop takes the OR output at a rising edge while `cfg_en` and `rst` are low, so the pin changes only at clock edges.
- R7: The flip-flop values act as present-state literals, so registered cells can be wired as a counter that steps on every enabled edge.
- R8: `rst` high at a rising edge clears every flip-flop to 0. It takes priority over holding and over capturing.
- R9: While `oe` is low, all pins are high impedance. The flip-flops keep updating, and the next cycle with `oe` high shows the state they have reached.
- R10: While `cfg_en` is high and `rst` is low, the flip-flops hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for the flip-flops and the chain |
| rst | input | 1 | Synchronous clear of the macrocell flip-flops |
| cfg_en | input | 1 | Shift enable for the configuration chain; freezes the flip-flops |
| cfg_in | input | 1 | Serial configuration data |
| oe | input | 1 | Shared output enable for all pins |
| in_pins | input | N_IN | Dedicated logic inputs |
| out_pins | output | N_CELL | Tri-state macrocell pins |

## Verification
The assertions check on every clock that the chain shifts by exactly one place with `cfg_in` entering at the bottom, and that it stays still otherwise. They also check that each flip-flop clears after reset, holds during loading, and otherwise captures the OR output of the previous cycle. The bench scenarios are needed to show the rest: the literal encoding and the fully connected term, the feedback counter, the mode selection after a reload, high impedance with registers still moving, and configuration that survives a reset. A behavioural model in the bench predicts the pins and checks them every cycle.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Per-cell pin source selected by the cell's mode bit.
    typedef enum logic {
        MODE_COMB = 1'b0,
        MODE_REG  = 1'b1
    } out_mode_e;

endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         sin,
    output logic [W-1:0] bits
);

    always_ff @(posedge clk) begin
        if (shift_en) begin
            bits <= {bits[W-2:0], sin};
        end
    end

    AST_CFG_SHIFT: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (bits[0] == $past(sin)) && (bits[W-1:1] == $past(bits[W-2:0]))); // R1

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(bits)); // R2

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_pkg::*;
#(
    parameter int LIT_W = 16,
    parameter int N_PT  = 3,
    localparam int CFG_BITS = N_PT * LIT_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  logic [LIT_W-1:0]    lits,
    input  logic [CFG_BITS-1:0] cell_cfg,
    output logic                q,
    output logic                pin_val
);

    logic [N_PT-1:0] pt;
    logic            sum;
    out_mode_e       mode;

    // Programmable AND plane: unconnected literals read as 1.
    for (genvar t = 0; t < N_PT; t++) begin : g_term
        assign pt[t] = &(lits | ~cell_cfg[1 + t*LIT_W +: LIT_W]);
    end

    // Fixed OR gate.
    assign sum  = |pt;
    assign mode = out_mode_e'(cell_cfg[0]);

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (!hold) begin
            q <= sum;
        end
    end

    // Output selection.
    always_comb begin
        unique case (mode)
            MODE_COMB: pin_val = sum;
            MODE_REG:  pin_val = q;
        endcase
    end

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (q == 1'b0)); // R8

    AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q)); // R10

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !hold |=> (q == $past(sum))); // R6

endmodule

// File: rtl/pal_array.sv
module pal_array #(
    parameter int N_IN   = 4,
    parameter int N_CELL = 4,
    parameter int N_PT   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_en,
    input  logic              cfg_in,
    input  logic              oe,
    input  logic [N_IN-1:0]   in_pins,
    output logic [N_CELL-1:0] out_pins
);

    localparam int N_SIG  = N_IN + N_CELL;
    localparam int LIT_W  = 2 * N_SIG;
    localparam int CELL_W = N_PT * LIT_W + 1;
    localparam int CFG_W  = N_CELL * CELL_W;

    logic [CFG_W-1:0]  cfg_bits;
    logic [N_CELL-1:0] q_vec;
    logic [N_CELL-1:0] pin_vec;
    logic [N_SIG-1:0]  sig;
    logic [LIT_W-1:0]  lits;

    pal_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .sin      (cfg_in),
        .bits     (cfg_bits)
    );

    // Inputs first, then flip-flop feedback as present-state signals.
    assign sig = {q_vec, in_pins};

    for (genvar k = 0; k < N_SIG; k++) begin : g_lit
        assign lits[2*k]   = sig[k];
        assign lits[2*k+1] = ~sig[k];
    end

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        pal_macrocell #(.LIT_W(LIT_W), .N_PT(N_PT)) u_cell (
            .clk      (clk),
            .rst      (rst),
            .hold     (cfg_en),
            .lits     (lits),
            .cell_cfg (cfg_bits[c*CELL_W +: CELL_W]),
            .q        (q_vec[c]),
            .pin_val  (pin_vec[c])
        );
    end

    // Shared output enable on the tri-state stage.
    assign out_pins = oe ? pin_vec : {N_CELL{1'bz}};

endmodule

// File: tb/tb_pal_array.sv
`timescale 1ns/100ps
module tb_pal_array;

    localparam int N_IN   = 4;
    localparam int N_CELL = 4;
    localparam int N_PT   = 3;
    localparam int N_SIG  = N_IN + N_CELL;
    localparam int LIT_W  = 2 * N_SIG;
    localparam int CELL_W = N_PT * LIT_W + 1;
    localparam int CFG_W  = N_CELL * CELL_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0;
    logic cfg_in = 1'b0;
    logic oe = 1'b0;
    logic [N_IN-1:0] in_pins = '0;
    wire  [N_CELL-1:0] out_pins;

    pal_array #(.N_IN(N_IN), .N_CELL(N_CELL), .N_PT(N_PT)) dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_in(cfg_in),
        .oe(oe), .in_pins(in_pins), .out_pins(out_pins)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // Behavioural reference state.
    bit m_cfg [CFG_W];
    bit m_q   [N_CELL];
    logic [CFG_W-1:0] img_a, img_b;

    function automatic int lit_pos(int c, int t, int k, bit neg);
        return c*CELL_W + 1 + t*LIT_W + 2*k + (neg ? 1 : 0);
    endfunction

    function automatic bit m_sig(int k, logic [N_IN-1:0] inp);
        if (k < N_IN) return inp[k];
        return m_q[k-N_IN];
    endfunction

    function automatic bit m_sum(int c, logic [N_IN-1:0] inp);
        bit s = 1'b0;
        for (int t = 0; t < N_PT; t++) begin
            bit term = 1'b1;
            for (int k = 0; k < N_SIG; k++) begin
                if (m_cfg[lit_pos(c, t, k, 1'b0)]) term &= m_sig(k, inp);
                if (m_cfg[lit_pos(c, t, k, 1'b1)]) term &= ~m_sig(k, inp);
            end
            s |= term;
        end
        return s;
    endfunction

    task automatic cyc(input logic [N_IN-1:0] inp, input logic o, input logic cen,
                       input logic cin, input logic r, input string tag);
        logic [N_CELL-1:0] exp_v;
        bit nq [N_CELL];
        in_pins = inp; oe = o; cfg_en = cen; cfg_in = cin; rst = r;
        #1;
        if (chk_on) begin
            for (int c = 0; c < N_CELL; c++) begin
                bit v = m_cfg[c*CELL_W] ? m_q[c] : m_sum(c, inp);
                exp_v[c] = o ? v : 1'bz;
            end
            checks++;
            if (out_pins !== exp_v) begin
                errors++;
                $display("FAIL %s: out_pins=%b expected=%b", tag, out_pins, exp_v);
            end
        end
        for (int c = 0; c < N_CELL; c++) begin
            if (r) nq[c] = 1'b0;
            else if (cen) nq[c] = m_q[c];
            else nq[c] = m_sum(c, inp);
        end
        @(posedge clk);
        for (int c = 0; c < N_CELL; c++) m_q[c] = nq[c];
        if (cen) begin
            for (int i = CFG_W-1; i > 0; i--) m_cfg[i] = m_cfg[i-1];
            m_cfg[0] = cin;
        end
        @(negedge clk);
    endtask

    task automatic load(input logic [CFG_W-1:0] img, input logic [N_IN-1:0] inp,
                        input logic r, input string tag);
        for (int i = CFG_W-1; i >= 0; i--) cyc(inp, 1'b1, 1'b1, img[i], r, tag);
    endtask

    function automatic logic [CFG_W-1:0] full_term(logic [CFG_W-1:0] img, int c, int t);
        for (int k = 0; k < N_SIG; k++) begin
            img[lit_pos(c, t, k, 1'b0)] = 1'b1;
            img[lit_pos(c, t, k, 1'b1)] = 1'b1;
        end
        return img;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

    initial begin
        // Image A: cells 0,1 form a 2-bit counter enabled by in0 (R7).
        img_a = '0;
        // cell0: q0&~in0 | ~q0&in0, third term fully connected (R4)
        img_a[0*CELL_W] = 1'b1;
        img_a[lit_pos(0,0,4,0)] = 1; img_a[lit_pos(0,0,0,1)] = 1;
        img_a[lit_pos(0,1,4,1)] = 1; img_a[lit_pos(0,1,0,0)] = 1;
        img_a = full_term(img_a, 0, 2);
        // cell1: q1&~q0 | q1&~in0 | ~q1&q0&in0
        img_a[1*CELL_W] = 1'b1;
        img_a[lit_pos(1,0,5,0)] = 1; img_a[lit_pos(1,0,4,1)] = 1;
        img_a[lit_pos(1,1,5,0)] = 1; img_a[lit_pos(1,1,0,1)] = 1;
        img_a[lit_pos(1,2,5,1)] = 1; img_a[lit_pos(1,2,4,0)] = 1; img_a[lit_pos(1,2,0,0)] = 1;
        // cell2 combinational: in1&in2 | ~in3
        img_a[lit_pos(2,0,1,0)] = 1; img_a[lit_pos(2,0,2,0)] = 1;
        img_a[lit_pos(2,1,3,1)] = 1;
        img_a = full_term(img_a, 2, 2);
        // cell3 combinational: q1&~in0
        img_a[lit_pos(3,0,5,0)] = 1; img_a[lit_pos(3,0,0,1)] = 1;
        img_a = full_term(img_a, 3, 1);
        img_a = full_term(img_a, 3, 2);
        // Image B: same terms, modes swapped on cells 0, 2, 3.
        img_b = img_a;
        img_b[0*CELL_W] = 1'b0;
        img_b[2*CELL_W] = 1'b1;
        img_b[3*CELL_W] = 1'b1;
        for (int i = 0; i < CFG_W; i++) m_cfg[i] = 1'b0;
        for (int c = 0; c < N_CELL; c++) m_q[c] = 1'b0;

        @(negedge clk);
        load(img_a, 4'b0000, 1'b1, "R1");
        chk_on = 1'b1;
        // Reset state: registered pins read 0 (R8).
        for (int i = 0; i < 2; i++) cyc(4'b0000, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        // Counter driven by in0 (R6 R7).
        for (int i = 0; i < 6; i++) cyc(4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, "R6 R7");
        // Combinational sweep of in1..in3, counter paused (R3 R4 R5).
        for (int v = 0; v < 8; v++) cyc({v[2:0], 1'b0}, 1'b1, 1'b0, 1'b0, 1'b0, "R3 R4 R5");
        // Pins released while counting continues (R9).
        for (int i = 0; i < 3; i++) cyc(4'b0001, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        cyc(4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        // Mid-run reset keeps configuration (R2 R8).
        for (int i = 0; i < 2; i++) cyc(4'b0101, 1'b1, 1'b0, 1'b0, 1'b1, "R2 R8");
        for (int v = 0; v < 8; v++) cyc({v[2:0], 1'b1}, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        // Reload with counting input active: flip-flops frozen (R1 R10).
        load(img_b, 4'b0001, 1'b0, "R1 R10");
        // Random operation under image B (R3 R5 R6 R7 R9).
        for (int i = 0; i < 400; i++) begin
            logic [N_IN-1:0] rin = N_IN'($urandom);
            logic ro = ($urandom % 4) != 0;
            logic rr = ($urandom % 40) == 0;
            cyc(rin, ro, 1'b0, 1'b0, rr, "R3 R5 R6 R7 R9");
        end
        // Back to image A and a final random run.
        load(img_a, 4'b0110, 1'b0, "R1 R10");
        for (int i = 0; i < 200; i++) begin
            logic [N_IN-1:0] rin = N_IN'($urandom);
            cyc(rin, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R5 R6 R7");
        end
        done = 1'b1;
        finish_run();
    end

endmodule